// File: doc/BRIEF.md
# Paged DMA Address Walker

This block turns one linear DMA transfer into a series of physical memory bursts. The transfer is given as a start address, a byte count and a direction. The walker cuts the transfer wherever it crosses a 4096-byte page. For each piece it reads one word from a one-level mapping table in memory, which gives the physical frame of that page. It then issues one burst to that frame, offset by the position inside the page.

The table base and the table size in bytes come from configuration inputs, which are held steady while a walk runs. Each page is looked up again every time; no entries are kept between pieces. A page beyond the end of the table stops the walk. The walker then reports an error together with the number of bytes already moved. Both the entry read and the data burst use a valid/ready request, and only one request is in flight at any time.

Top module: `dpw_page_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `range_err`, `ent_req_valid` and `mem_req_valid` are all 0.
- R2: A `start` pulse is taken only while `busy` is 0, and `busy` rises on the next cycle. A `start` seen while `busy` is 1 changes neither the running walk nor its result, and it does not launch a second walk.
- R3: For every piece, the entry read address is `tbl_base + (linear_address >> 12) * 8`. Each table entry is 8 bytes, and the 32-bit frame word sits at the lowest address of the entry.
- R4: The burst address is the returned frame word plus the low 12 bits of the current linear address.
- R5: Each burst length is the smaller of two values: the bytes left before the next 4096-byte boundary and the bytes still to move. After each burst completes, the linear address and the moved count both grow by that length. Every piece performs its own entry read.
- R6: A page index (linear address >> 12) that is at or above `tbl_limit >> 3` ends the walk before that page's entry read. In that case `range_err` and `done` pulse together for one cycle, and `done_count` holds the bytes moved so far.
- R7: A walk that reaches the requested length pulses `done` for one cycle with `range_err` at 0 and `done_count` equal to the length. A zero length finishes with no request at all.
- R8: `mem_req_write` carries the `dir_write` value captured at start (1 = write to memory) on every burst of the walk.
- R9: A request stays asserted with stable address, length and direction until it is accepted. The entry and data requests are never asserted together. The next request waits for `ent_rsp_valid` or `mem_done` of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a walk (taken when idle) |
| start_addr | input | 32 | Linear start address |
| xfer_len | input | 16 | Bytes to transfer |
| dir_write | input | 1 | 1 = bursts write memory, 0 = read |
| tbl_base | input | 32 | Physical address of the mapping table |
| tbl_limit | input | 32 | Table size in bytes |
| ent_req_valid | output | 1 | Entry read request valid |
| ent_req_ready | input | 1 | Entry read request accepted |
| ent_req_addr | output | 32 | Address of the entry's frame word |
| ent_rsp_valid | input | 1 | Frame word returned |
| ent_rsp_data | input | 32 | Frame word |
| mem_req_valid | output | 1 | Data burst request valid |
| mem_req_ready | input | 1 | Data burst request accepted |
| mem_req_addr | output | 32 | Physical burst address |
| mem_req_len | output | 13 | Burst length in bytes (1..4096) |
| mem_req_write | output | 1 | Burst direction |
| mem_done | input | 1 | Burst completed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| range_err | output | 1 | One-cycle pulse: walk stopped at the table limit |
| done_count | output | 16 | Bytes moved, valid with `done` |

## Verification
A wrong linear address or moved count shows up at the next entry request: that request carries the wrong entry address, and the next burst carries the wrong offset or length. A wrong latched frame is visible on the very next burst address. A corrupted state register shows up within a cycle or two, either as two requests at once or as a request that drops before acceptance. A wrong limit comparison only appears when a walk reaches the table edge, as a missing or spurious `range_err` and a wrong `done_count`. For that reason the vectors place walks that start on, cross or stop exactly at the last entry.

// File: rtl/dpw_pkg.sv
// Shared types for the paged DMA walker.
package dpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ENT_REQ,
        ST_ENT_WAIT,
        ST_DAT_REQ,
        ST_DAT_WAIT
    } walk_state_t;

endpackage

// File: rtl/dpw_chunk_calc.sv
// Combinational address arithmetic for one piece of a walk.
// It derives the page index, the in-page offset, the entry address, the
// physical burst address from a frame word, the piece length and the
// limit test. It assumes the table limit is given in bytes.
module dpw_chunk_calc #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    parameter int ENT_LOG2  = 3
) (
    input  logic [ADDR_W-1:0]  lin_addr,
    input  logic [LEN_W-1:0]   bytes_left,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [ADDR_W-1:0]  tbl_limit,
    input  logic [ADDR_W-1:0]  frame_word,
    output logic [ADDR_W-1:0]  ent_addr,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic [PAGE_BITS:0] chunk_len,
    output logic               beyond_limit
);
    localparam int CHUNK_W = PAGE_BITS + 1;
    localparam int CMP_W   = LEN_W + CHUNK_W;
    localparam logic [CHUNK_W-1:0] PAGE_BYTES = CHUNK_W'(1) << PAGE_BITS;

    logic [PAGE_BITS-1:0] page_off;
    logic [ADDR_W-1:0]    page_idx;
    logic [ADDR_W-1:0]    max_entries;
    logic [CHUNK_W-1:0]   to_page_end;
    logic [CMP_W-1:0]     left_ext;
    logic [CMP_W-1:0]     end_ext;

    // Split the linear address into page index and offset.
    assign page_off    = lin_addr[PAGE_BITS-1:0];
    assign page_idx    = lin_addr >> PAGE_BITS;
    assign max_entries = tbl_limit >> ENT_LOG2;

    // Bytes left before the next page boundary.
    assign to_page_end = PAGE_BYTES - {1'b0, page_off};
    assign left_ext    = CMP_W'(bytes_left);
    assign end_ext     = CMP_W'(to_page_end);

    // Piece length, addresses and limit test.
    always_comb begin
        chunk_len    = (left_ext < end_ext) ? CHUNK_W'(bytes_left) : to_page_end;
        ent_addr     = tbl_base + (page_idx << ENT_LOG2);
        phys_addr    = frame_word + ADDR_W'(page_off);
        beyond_limit = (page_idx >= max_entries);
    end

endmodule

// File: rtl/dpw_walk_fsm.sv
// Sequencer for one walk. It captures the request, checks each page
// against the table limit, issues the entry read, then the burst, and
// advances after the burst completes. It assumes that responses come at
// least one cycle after their request was accepted, and that the
// configuration inputs stay steady during a walk.
module dpw_walk_fsm
    import dpw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic               dir_write,
    // from the address calculator
    input  logic [ADDR_W-1:0]  calc_ent_addr,
    input  logic [ADDR_W-1:0]  calc_phys_addr,
    input  logic [PAGE_BITS:0] calc_chunk_len,
    input  logic               calc_beyond,
    // to the address calculator
    output logic [ADDR_W-1:0]  lin_addr,
    output logic [LEN_W-1:0]   bytes_left,
    // entry read port
    output logic               ent_req_valid,
    input  logic               ent_req_ready,
    output logic [ADDR_W-1:0]  ent_req_addr,
    input  logic               ent_rsp_valid,
    // data burst port
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [PAGE_BITS:0] mem_req_len,
    output logic               mem_req_write,
    input  logic               mem_done,
    // status
    output logic               busy,
    output logic               done,
    output logic               range_err,
    output logic [LEN_W-1:0]   done_count
);
    walk_state_t          state;
    logic [LEN_W-1:0]     len_req;
    logic [LEN_W-1:0]     moved;
    logic                 write_r;
    logic [ADDR_W-1:0]    ent_addr_r;
    logic [ADDR_W-1:0]    dat_addr_r;
    logic [PAGE_BITS:0]   dat_len_r;

    // Bytes still to move, fed to the calculator.
    assign bytes_left = len_req - moved;

    // Port drive from the registered state.
    assign busy          = (state != ST_IDLE);
    assign ent_req_valid = (state == ST_ENT_REQ);
    assign ent_req_addr  = ent_addr_r;
    assign mem_req_valid = (state == ST_DAT_REQ);
    assign mem_req_addr  = dat_addr_r;
    assign mem_req_len   = dat_len_r;
    assign mem_req_write = write_r;

    // Walk sequencing, request registers and end-of-walk pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lin_addr   <= '0;
            len_req    <= '0;
            moved      <= '0;
            write_r    <= 1'b0;
            ent_addr_r <= '0;
            dat_addr_r <= '0;
            dat_len_r  <= '0;
            done       <= 1'b0;
            range_err  <= 1'b0;
            done_count <= '0;
        end else begin
            done      <= 1'b0;
            range_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lin_addr <= start_addr;
                        len_req  <= xfer_len;
                        moved    <= '0;
                        write_r  <= dir_write;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (moved == len_req) begin
                        done       <= 1'b1;
                        done_count <= moved;
                        state      <= ST_IDLE;
                    end else if (calc_beyond) begin
                        done       <= 1'b1;
                        range_err  <= 1'b1;
                        done_count <= moved;
                        state      <= ST_IDLE;
                    end else begin
                        ent_addr_r <= calc_ent_addr;
                        state      <= ST_ENT_REQ;
                    end
                end
                ST_ENT_REQ: begin
                    if (ent_req_ready) state <= ST_ENT_WAIT;
                end
                ST_ENT_WAIT: begin
                    if (ent_rsp_valid) begin
                        dat_addr_r <= calc_phys_addr;
                        dat_len_r  <= calc_chunk_len;
                        state      <= ST_DAT_REQ;
                    end
                end
                ST_DAT_REQ: begin
                    if (mem_req_ready) state <= ST_DAT_WAIT;
                end
                ST_DAT_WAIT: begin
                    if (mem_done) begin
                        lin_addr <= lin_addr + ADDR_W'(dat_len_r);
                        moved    <= moved + LEN_W'(dat_len_r);
                        state    <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dpw_page_walker.sv
// Top of the paged DMA walker. It splits a linear transfer at page
// boundaries, reads one mapping entry per piece and issues one burst per
// piece. Only the frame word of each entry is used. It assumes steady
// table configuration during a walk.
module dpw_page_walker #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    parameter int ENT_LOG2  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic               dir_write,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [ADDR_W-1:0]  tbl_limit,
    output logic               ent_req_valid,
    input  logic               ent_req_ready,
    output logic [ADDR_W-1:0]  ent_req_addr,
    input  logic               ent_rsp_valid,
    input  logic [ADDR_W-1:0]  ent_rsp_data,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [PAGE_BITS:0] mem_req_len,
    output logic               mem_req_write,
    input  logic               mem_done,
    output logic               busy,
    output logic               done,
    output logic               range_err,
    output logic [LEN_W-1:0]   done_count
);
    logic [ADDR_W-1:0]  lin_addr;
    logic [LEN_W-1:0]   bytes_left;
    logic [ADDR_W-1:0]  calc_ent_addr;
    logic [ADDR_W-1:0]  calc_phys_addr;
    logic [PAGE_BITS:0] calc_chunk_len;
    logic               calc_beyond;

    dpw_chunk_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2)
    ) u_calc (
        .lin_addr    (lin_addr),
        .bytes_left  (bytes_left),
        .tbl_base    (tbl_base),
        .tbl_limit   (tbl_limit),
        .frame_word  (ent_rsp_data),
        .ent_addr    (calc_ent_addr),
        .phys_addr   (calc_phys_addr),
        .chunk_len   (calc_chunk_len),
        .beyond_limit(calc_beyond)
    );

    dpw_walk_fsm #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_addr    (start_addr),
        .xfer_len      (xfer_len),
        .dir_write     (dir_write),
        .calc_ent_addr (calc_ent_addr),
        .calc_phys_addr(calc_phys_addr),
        .calc_chunk_len(calc_chunk_len),
        .calc_beyond   (calc_beyond),
        .lin_addr      (lin_addr),
        .bytes_left    (bytes_left),
        .ent_req_valid (ent_req_valid),
        .ent_req_ready (ent_req_ready),
        .ent_req_addr  (ent_req_addr),
        .ent_rsp_valid (ent_rsp_valid),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_len   (mem_req_len),
        .mem_req_write (mem_req_write),
        .mem_done      (mem_done),
        .busy          (busy),
        .done          (done),
        .range_err     (range_err),
        .done_count    (done_count)
    );

endmodule

// File: rtl/dpw_walk_checker.sv
// Protocol and result properties of the walker, bound to its top.
module dpw_walk_checker #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12,
    parameter int ENT_LOG2  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LEN_W-1:0]   xfer_len,
    input logic [ADDR_W-1:0]  tbl_base,
    input logic               ent_req_valid,
    input logic               ent_req_ready,
    input logic [ADDR_W-1:0]  ent_req_addr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [PAGE_BITS:0] mem_req_len,
    input logic               mem_req_write,
    input logic               busy,
    input logic               done,
    input logic               range_err,
    input logic [LEN_W-1:0]   done_count
);
    localparam logic [PAGE_BITS:0] PAGE_BYTES = (PAGE_BITS+1)'(1) << PAGE_BITS;
    localparam logic [ADDR_W-1:0]  ENT_MASK   = (ADDR_W'(1) << ENT_LOG2) - 1;

    logic [LEN_W-1:0] took_len;

    // Length of the walk currently accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) took_len <= '0;
        else if (start && !busy) took_len <= xfer_len;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    p_ent_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req_valid |-> (((ent_req_addr - tbl_base) & ENT_MASK) == '0));
    p_chunk_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_len != '0) && (mem_req_len <= PAGE_BYTES));
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> done);
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= took_len) && !busy);
    p_ent_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req_valid && !ent_req_ready |=> ent_req_valid && $stable(ent_req_addr));
    p_dat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_len) && $stable(mem_req_write));
    p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_req_valid && mem_req_valid));

endmodule

bind dpw_page_walker dpw_walk_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2)
) u_walk_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .xfer_len     (xfer_len),
    .tbl_base     (tbl_base),
    .ent_req_valid(ent_req_valid),
    .ent_req_ready(ent_req_ready),
    .ent_req_addr (ent_req_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_len  (mem_req_len),
    .mem_req_write(mem_req_write),
    .busy         (busy),
    .done         (done),
    .range_err    (range_err),
    .done_count   (done_count)
);

// File: tb/dpw_page_walker_bench.sv
`timescale 1ns/1ps
module dpw_page_walker_bench;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic        wr;
        logic [31:0] base;
        logic [31:0] limit;
        logic [15:0] cnt;
        logic        err;
        logic [3:0]  nch;
        logic        bp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 16'h0200, 1'b0, 32'h0010_0000, 32'h100, 16'h0200, 1'b0, 4'd1, 1'b0},
        '{32'h0000_0F00, 16'h0300, 1'b1, 32'h0010_0000, 32'h100, 16'h0300, 1'b0, 4'd2, 1'b0},
        '{32'h0000_1000, 16'h2000, 1'b0, 32'h0010_0000, 32'h100, 16'h2000, 1'b0, 4'd2, 1'b1},
        '{32'h0001_F800, 16'h1000, 1'b1, 32'h0010_0000, 32'h100, 16'h0800, 1'b1, 4'd1, 1'b0},
        '{32'h0002_0000, 16'h0010, 1'b0, 32'h0010_0000, 32'h100, 16'h0000, 1'b1, 4'd0, 1'b0},
        '{32'h0000_3000, 16'h0000, 1'b0, 32'h0010_0000, 32'h100, 16'h0000, 1'b0, 4'd0, 1'b0},
        '{32'h0002_0000, 16'h0010, 1'b1, 32'h0010_0000, 32'h10F, 16'h0010, 1'b0, 4'd1, 1'b1},
        '{32'h0000_2FFF, 16'h2002, 1'b0, 32'h0020_0008, 32'h100, 16'h2002, 1'b0, 4'd4, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] xfer_len = '0;
    logic        dir_write = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [31:0] tbl_limit = '0;
    logic        ent_req_valid;
    logic        ent_req_ready = 1'b0;
    logic [31:0] ent_req_addr;
    logic        ent_rsp_valid = 1'b0;
    logic [31:0] ent_rsp_data = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [12:0] mem_req_len;
    logic        mem_req_write;
    logic        mem_done = 1'b0;
    logic        busy;
    logic        done;
    logic        range_err;
    logic [15:0] done_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic bp     = 1'b0;

    // logs of accepted requests
    logic [31:0] ent_log [16];
    logic [31:0] dat_addr_log [16];
    logic [12:0] dat_len_log [16];
    logic        dat_wr_log [16];
    int n_ent = 0;
    int n_dat = 0;

    // responder bookkeeping
    int          ent_delay = -1;
    logic [31:0] ent_pend_addr = '0;
    int          dat_delay = -1;

    always #2.5 clk = ~clk;

    dpw_page_walker u_dpw_page_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .xfer_len(xfer_len), .dir_write(dir_write), .tbl_base(tbl_base),
        .tbl_limit(tbl_limit), .ent_req_valid(ent_req_valid),
        .ent_req_ready(ent_req_ready), .ent_req_addr(ent_req_addr),
        .ent_rsp_valid(ent_rsp_valid), .ent_rsp_data(ent_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_req_write(mem_req_write), .mem_done(mem_done), .busy(busy),
        .done(done), .range_err(range_err), .done_count(done_count)
    );

    // Frame word the bench memory holds for a given entry address.
    function automatic logic [31:0] frame_of(input logic [31:0] ea);
        return 32'hA000_0000 ^ (ea << 9);
    endfunction

    // Memory model: back-pressure, delayed responses, request logging.
    always @(negedge clk) begin
        cyc = cyc + 1;
        ent_rsp_valid = 1'b0;
        mem_done = 1'b0;
        if (ent_delay == 0) begin
            ent_rsp_valid = 1'b1;
            ent_rsp_data = frame_of(ent_pend_addr);
        end
        if (ent_delay >= 0) ent_delay = ent_delay - 1;
        if (dat_delay == 0) mem_done = 1'b1;
        if (dat_delay >= 0) dat_delay = dat_delay - 1;
        ent_req_ready = bp ? ((cyc % 3) == 0) : 1'b1;
        mem_req_ready = bp ? ((cyc % 4) == 1) : 1'b1;
        if (ent_req_valid && ent_req_ready) begin
            if (n_ent < 16) ent_log[n_ent] = ent_req_addr;
            n_ent = n_ent + 1;
            ent_pend_addr = ent_req_addr;
            ent_delay = bp ? 3 : 1;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (n_dat < 16) begin
                dat_addr_log[n_dat] = mem_req_addr;
                dat_len_log[n_dat]  = mem_req_len;
                dat_wr_log[n_dat]   = mem_req_write;
            end
            n_dat = n_dat + 1;
            dat_delay = bp ? 4 : 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end

    task automatic launch(input logic [31:0] a, input logic [15:0] l, input logic w,
                          input logic [31:0] b, input logic [31:0] lim);
        @(negedge clk);
        n_ent = 0;
        n_dat = 0;
        start_addr = a;
        xfer_len = l;
        dir_write = w;
        tbl_base = b;
        tbl_limit = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Compare the logged requests against a walk worked out from R3..R8.
    task automatic check_walk(input vec_t v);
        logic [31:0] a;
        int moved;
        int k;
        int c;
        int off;
        logic [31:0] ea;
        a = v.addr;
        moved = 0;
        k = 0;
        while (moved < int'(v.len)) begin
            if ((a >> 12) >= (v.limit >> 3)) break;
            ea = v.base + ((a >> 12) << 3);
            off = int'(a[11:0]);
            c = 4096 - off;
            if (int'(v.len) - moved < c) c = int'(v.len) - moved;
            if (k < 16 && k < n_ent)
                chk(ent_log[k] == ea, "R3 entry address", 64'(ent_log[k]), 64'(ea));
            if (k < 16 && k < n_dat) begin
                chk(dat_addr_log[k] == frame_of(ea) + 32'(off), "R4 burst address",
                    64'(dat_addr_log[k]), 64'(frame_of(ea) + 32'(off)));
                chk(int'(dat_len_log[k]) == c, "R5 burst length",
                    64'(dat_len_log[k]), 64'(c));
                chk(dat_wr_log[k] == v.wr, "R8 direction", 64'(dat_wr_log[k]), 64'(v.wr));
            end
            a = a + 32'(c);
            moved = moved + c;
            k++;
        end
        chk(k == int'(v.nch), "R5 model piece count", 64'(k), 64'(v.nch));
        chk(n_ent == k, "R5 one entry read per piece", 64'(n_ent), 64'(k));
        chk(n_dat == k, "R5 burst count", 64'(n_dat), 64'(k));
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
        chk(done == 1'b0, "R1 done", 64'(done), 0);
        chk(range_err == 1'b0, "R1 range_err", 64'(range_err), 0);
        chk(ent_req_valid == 1'b0 && mem_req_valid == 1'b0, "R1 requests",
            64'({ent_req_valid, mem_req_valid}), 0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            bp = VECS[i].bp;
            launch(VECS[i].addr, VECS[i].len, VECS[i].wr, VECS[i].base, VECS[i].limit);
            chk(busy == 1'b1 || done == 1'b1, "R2 accepted", 64'(busy), 1);
            wait_done(seen);
            chk(seen, "R7 walk finished", 64'(seen), 1);
            chk(done_count == VECS[i].cnt,
                VECS[i].err ? "R6 bytes before limit" : "R7 full count",
                64'(done_count), 64'(VECS[i].cnt));
            chk(range_err == VECS[i].err, "R6 range_err", 64'(range_err),
                64'(VECS[i].err));
            check_walk(VECS[i]);
            @(negedge clk);
            chk(done == 1'b0 && range_err == 1'b0, "R7 single-cycle pulse",
                64'({done, range_err}), 0);
        end

        // R2: start while busy is ignored
        bp = 1'b1;
        launch(32'h0000_0F00, 16'h0300, 1'b1, 32'h0010_0000, 32'h100);
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R2 still busy", 64'(busy), 1);
        start_addr = 32'h0000_5000;
        xfer_len = 16'h0010;
        dir_write = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen && done_count == 16'h0300, "R2 result unchanged", 64'(done_count), 64'h300);
        chk(n_dat == 2, "R2 no extra bursts", 64'(n_dat), 2);
        chk(dat_wr_log[1] == 1'b1, "R2 direction kept", 64'(dat_wr_log[1]), 1);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0 && n_ent == 2, "R2 no second walk", 64'({busy, 8'(n_ent)}), 2);

        // R9: nothing requested while the entry response is withheld
        bp = 1'b0;
        launch(32'h0000_0040, 16'h0008, 1'b0, 32'h0010_0000, 32'h100);
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R9 burst waits for entry", 64'(mem_req_valid), 0);
        wait_done(seen);
        chk(seen && done_count == 16'h0008 && !range_err, "R9 walk completes",
            64'(done_count), 64'h8);

        // R1: reset in the middle of a walk returns to idle
        bp = 1'b1;
        launch(32'h0000_0000, 16'h3000, 1'b0, 32'h0010_0000, 32'h100);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !ent_req_valid && !mem_req_valid && !done, "R1 reset mid-walk",
            64'({busy, ent_req_valid, mem_req_valid, done}), 0);
        rst_n = 1'b1;
        ent_delay = -1;
        dat_delay = -1;
        repeat (3) @(negedge clk);

        finish_run();
    end

endmodule